// File: doc/BRIEF.md
# Parallel Flash Command Sequencer with Write Buffer

This block is the command front end of a parallel NOR-style flash device. Bus write cycles carry command bytes, addresses and data. The block decodes the multi-cycle sequences for single program, buffered write, block erase, and block lock set or clear. When a sequence is valid, it starts a simple write state machine (WSM). That machine works on a byte register file standing in for the array, and it stays busy for a fixed, counted number of cycles. Reads return array data, the status byte or the extended status byte, depending on the last mode command.

The `x16_mode` pin selects the bus width and is held static. In word mode, addresses count 16-bit words, and byte `2a` is the low lane of word `a`. In byte mode, addresses count bytes, and only the low data lane is used. Programming can only clear bits: each written byte is ANDed into the array. Erase sets every byte of a block back to FFh. A block is 32 bytes.

The write port is valid/ready. A cycle is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops in the cycle after an operation starts and rises again when the WSM finishes. While it is low, the host must hold its cycle, and no command, address or data is taken. Reads are combinational and need no handshake.

Top module: `flash_cmd_seq`

## Requirements
- R1: Either 40h or 10h, followed by one data cycle, programs one word (word mode) or one byte (byte mode) at that cycle's address. Each target byte becomes old AND new.
- R2: E8h, then a count cycle N, then exactly N+1 data cycles, then D0h programs the collected data. The data starts at the address of the first data cycle and fills consecutive locations. Nothing changes in the array before D0h.
- R3: The count N must be 0 to 1Fh in byte mode or 0 to 000Fh in word mode; the upper limits are accepted. A larger N is a sequence error: status bits 5 and 4 are set, the sequencer returns to idle, and no data cycles are collected.
- R4: Any value other than D0h in the confirm slot of a buffered write aborts it. Status bits 5 and 4 are set, the buffer is discarded and the array is unchanged.
- R5: 20h followed by D0h sets all bytes of the addressed block to FFh and leaves other blocks unchanged. Any other value in the confirm slot aborts with status bits 5 and 4 set.
- R6: In word mode, bits 15:8 of a command write are ignored. Only bits 7:0 select the command.
- R7: While the WSM is busy, `wr_ready` is 0. A read in that time gives `rd_oe` = 0080h and `rd_data[7]` = 0 (not ready).
- R8: 60h followed by 01h locks the addressed block. 60h followed by D0h clears the lock bits of all blocks at once.
- R9: A program or erase aimed at a locked block leaves the array unchanged and does not make the WSM busy. It sets status bit 1 together with bit 4 (program) or bit 5 (erase).
- R10: FFh selects array reads, 70h selects status reads and E8h selects extended status reads (80h, buffer free). Any program, erase or lock setup also selects status reads. 50h clears status bits 5, 4 and 1. Status is {ready, 0, bit5, bit4, 0, 0, bit1, 0} on `rd_data[7:0]` with `rd_oe` = 00FFh. Array reads in word mode drive `rd_oe` = FFFFh; array reads in byte mode drive 00FFh.
- R11: After reset the array reads FFh everywhere, no block is locked, the mode is array read, `wr_ready` is 1 and status is 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x16_mode | input | 1 | 1 = word bus, 0 = byte bus (static) |
| wr_valid | input | 1 | Bus write cycle offered |
| wr_ready | output | 1 | Write cycle can be taken (WSM idle) |
| wr_addr | input | 7 | Write address (word or byte units) |
| wr_data | input | 16 | Command, count or program data |
| rd_addr | input | 7 | Read address (word or byte units) |
| rd_data | output | 16 | Read data |
| rd_oe | output | 16 | Per-bit drive mask of rd_data |

## Verification
The buffered write is tried with three kinds of count. A small count in word mode shows that data lands at consecutive words starting at the first data address and stops exactly after N+1 cycles. The largest legal count in each mode checks the upper range limits, and a count one past the limit must produce a sequence error instead of collecting data. Two aborts are also run: a wrong byte in the buffered-write confirm slot and a wrong byte in the erase confirm slot. Each is read back both from status and from the untouched array. Overlapping programs to one word separate AND behaviour from plain overwrite. Locked, relocked and unlocked blocks separate the error path from the normal one, and command writes with a non-zero upper byte show that only the low byte is decoded.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    WOP_PROG    = 2'd0,
    WOP_ERASE   = 2'd1,
    WOP_CLRLOCK = 2'd2,
    WOP_SETLOCK = 2'd3
  } wsm_op_e;

  typedef enum logic [1:0] {
    RM_ARRAY   = 2'd0,
    RM_STATUS  = 2'd1,
    RM_XSTATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    S_IDLE          = 3'd0,
    S_PROG_DATA     = 3'd1,
    S_BUF_COUNT     = 3'd2,
    S_BUF_DATA      = 3'd3,
    S_BUF_CONFIRM   = 3'd4,
    S_ERASE_CONFIRM = 3'd5,
    S_LOCK_CONFIRM  = 3'd6
  } seq_state_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;
  localparam logic [7:0] CMD_BUFWR   = 8'hE8;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SETLOCK = 8'h01;

  localparam logic [7:0] XSTAT_FREE  = 8'h80;

endpackage

// File: rtl/flash_wbuf.sv
module flash_wbuf #(
  parameter int BUF_BYTES = 32,
  localparam int BUF_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             two,
  input  logic [BUF_W-1:0] widx,
  input  logic [15:0]      wdata,
  input  logic [BUF_W-1:0] ridx,
  output logic [7:0]       rdata
);

  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata[7:0];
      if (two) mem[widx + BUF_W'(1)] <= wdata[15:8];
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_seq_pkg::*;
#(
  parameter int ARR_BYTES = 128,
  parameter int BLK_BYTES = 32,
  parameter int BUF_BYTES = 32,
  parameter int ERASE_CYC = 8,
  parameter int PROG_TAIL = 2,
  localparam int AW    = $clog2(ARR_BYTES),
  localparam int BOFF  = $clog2(BLK_BYTES),
  localparam int NBLK  = ARR_BYTES / BLK_BYTES,
  localparam int BUF_W = $clog2(BUF_BYTES),
  localparam int NB_W  = BUF_W + 1,
  localparam int CNT_W = $clog2(BUF_BYTES + ERASE_CYC + PROG_TAIL + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  wsm_op_e          op,
  input  logic [AW-1:0]    addr,
  input  logic [NB_W-1:0]  nbytes,
  output logic             busy,
  output logic             lock_hit,
  output logic [BUF_W-1:0] buf_idx,
  input  logic [7:0]       buf_byte,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_lo,
  output logic [7:0]       rd_hi
);

  logic [7:0]       arr [ARR_BYTES];
  logic [NBLK-1:0]  lock_q;
  logic             run_q;
  wsm_op_e          op_q;
  logic [AW-1:0]    base_q;
  logic [NB_W-1:0]  nb_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_c;
  logic             last_c;
  logic             wr_on;
  logic [AW-1:0]    wa;

  // A locked target refuses program and erase before any cycle is spent.
  assign lock_hit = start && (op == WOP_PROG || op == WOP_ERASE) &&
                    lock_q[addr[AW-1:BOFF]];

  always_comb begin
    case (op_q)
      WOP_PROG:  len_c = CNT_W'(nb_q) + CNT_W'(PROG_TAIL);
      WOP_ERASE: len_c = CNT_W'(ERASE_CYC);
      default:   len_c = CNT_W'(1);
    endcase
  end

  assign last_c  = run_q && (cnt_q == len_c - CNT_W'(1));
  assign wr_on   = run_q && (op_q == WOP_PROG) && (cnt_q < CNT_W'(nb_q));
  assign wa      = base_q + AW'(cnt_q);
  assign buf_idx = BUF_W'(cnt_q);
  assign busy    = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      op_q   <= WOP_PROG;
      base_q <= '0;
      nb_q   <= '0;
      cnt_q  <= '0;
    end else if (start && !lock_hit) begin
      run_q  <= 1'b1;
      op_q   <= op;
      base_q <= addr;
      nb_q   <= nbytes;
      cnt_q  <= '0;
    end else if (run_q) begin
      if (last_c) run_q <= 1'b0;
      else        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_BYTES; i++) arr[i] <= 8'hFF;
      lock_q <= '0;
    end else begin
      if (wr_on) arr[wa] <= arr[wa] & buf_byte;
      if (last_c) begin
        case (op_q)
          WOP_ERASE: begin
            for (int i = 0; i < ARR_BYTES; i++)
              if ((i / BLK_BYTES) == int'(base_q[AW-1:BOFF])) arr[i] <= 8'hFF;
          end
          WOP_CLRLOCK: lock_q <= '0;
          WOP_SETLOCK: lock_q[base_q[AW-1:BOFF]] <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign rd_lo = arr[rd_addr];
  assign rd_hi = arr[rd_addr + AW'(1)];

  a_r7_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> !start);

  a_r9_locked_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && lock_hit) |=> !run_q);

  a_r5_erase_fills_block: assert property (@(posedge clk) disable iff (!rst_n)
    (last_c && op_q == WOP_ERASE) |=> (arr[{base_q[AW-1:BOFF], {BOFF{1'b0}}}] == 8'hFF));

  a_r8_clear_all_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (last_c && op_q == WOP_CLRLOCK) |=> (lock_q == '0));

endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_seq_pkg::*;
#(
  parameter int ARR_BYTES = 128,
  parameter int BUF_BYTES = 32,
  localparam int AW    = $clog2(ARR_BYTES),
  localparam int BUF_W = $clog2(BUF_BYTES),
  localparam int NB_W  = BUF_W + 1,
  localparam logic [15:0] BMAX = 16'(BUF_BYTES - 1),
  localparam logic [15:0] WMAX = 16'(BUF_BYTES / 2 - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             x16,
  input  logic [AW-1:0]    wr_addr,
  input  logic [15:0]      wr_data,
  input  logic             lock_hit,
  output logic             start,
  output wsm_op_e          op,
  output logic [AW-1:0]    st_addr,
  output logic [NB_W-1:0]  nbytes,
  output logic             bw_en,
  output logic             bw_two,
  output logic [BUF_W-1:0] bw_idx,
  output rd_mode_e         rmode,
  output logic [2:0]       err_bits
);

  seq_state_e      state_q, state_d;
  rd_mode_e        rmode_q, rmode_d;
  logic [BUF_W-1:0] cnt_q, cnt_d, idx_q, idx_d;
  logic [AW-1:0]   base_q, base_d, badr;
  logic [7:0]      cmd;
  logic            seq_err, clr_err, cnt_ok;
  logic            err_e_q, err_p_q, err_l_q;
  logic [NB_W-1:0] nb_one, nb_buf;

  assign cmd    = wr_data[7:0];
  assign badr   = x16 ? {wr_addr[AW-2:0], 1'b0} : wr_addr;
  assign cnt_ok = x16 ? (wr_data <= WMAX) : (wr_data <= BMAX);
  assign nb_one = NB_W'({1'b0, cnt_q}) + NB_W'(1);
  assign nb_buf = x16 ? (nb_one << 1) : nb_one;

  always_comb begin
    state_d = state_q;
    rmode_d = rmode_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    base_d  = base_q;
    start   = 1'b0;
    op      = WOP_PROG;
    st_addr = badr;
    nbytes  = '0;
    bw_en   = 1'b0;
    bw_two  = 1'b0;
    bw_idx  = '0;
    seq_err = 1'b0;
    clr_err = 1'b0;
    if (fire) begin
      case (state_q)
        S_IDLE: begin
          case (cmd)
            CMD_ARRAY:   rmode_d = RM_ARRAY;
            CMD_STATUS:  rmode_d = RM_STATUS;
            CMD_CLRSTAT: clr_err = 1'b1;
            CMD_PROG_A, CMD_PROG_B: begin
              state_d = S_PROG_DATA;
              rmode_d = RM_STATUS;
            end
            CMD_BUFWR: begin
              state_d = S_BUF_COUNT;
              rmode_d = RM_XSTATUS;
            end
            CMD_ERASE: begin
              state_d = S_ERASE_CONFIRM;
              rmode_d = RM_STATUS;
            end
            CMD_LOCK: begin
              state_d = S_LOCK_CONFIRM;
              rmode_d = RM_STATUS;
            end
            default: ;
          endcase
        end
        S_PROG_DATA: begin
          bw_en   = 1'b1;
          bw_two  = x16;
          start   = 1'b1;
          nbytes  = x16 ? NB_W'(2) : NB_W'(1);
          state_d = S_IDLE;
        end
        S_BUF_COUNT: begin
          rmode_d = RM_STATUS;
          if (cnt_ok) begin
            cnt_d   = wr_data[BUF_W-1:0];
            idx_d   = '0;
            state_d = S_BUF_DATA;
          end else begin
            seq_err = 1'b1;
            state_d = S_IDLE;
          end
        end
        S_BUF_DATA: begin
          bw_en  = 1'b1;
          bw_two = x16;
          bw_idx = x16 ? {idx_q[BUF_W-2:0], 1'b0} : idx_q;
          if (idx_q == '0) base_d = badr;
          if (idx_q == cnt_q) state_d = S_BUF_CONFIRM;
          else                idx_d   = idx_q + BUF_W'(1);
        end
        S_BUF_CONFIRM: begin
          if (cmd == CMD_CONFIRM) begin
            start   = 1'b1;
            st_addr = base_q;
            nbytes  = nb_buf;
          end else begin
            seq_err = 1'b1;
          end
          state_d = S_IDLE;
        end
        S_ERASE_CONFIRM: begin
          if (cmd == CMD_CONFIRM) begin
            start = 1'b1;
            op    = WOP_ERASE;
          end else begin
            seq_err = 1'b1;
          end
          state_d = S_IDLE;
        end
        S_LOCK_CONFIRM: begin
          if (cmd == CMD_CONFIRM) begin
            start = 1'b1;
            op    = WOP_CLRLOCK;
          end else if (cmd == CMD_SETLOCK) begin
            start = 1'b1;
            op    = WOP_SETLOCK;
          end else begin
            seq_err = 1'b1;
          end
          state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rmode_q <= RM_ARRAY;
      cnt_q   <= '0;
      idx_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      rmode_q <= rmode_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_e_q <= 1'b0;
      err_p_q <= 1'b0;
      err_l_q <= 1'b0;
    end else begin
      if (clr_err) begin
        err_e_q <= 1'b0;
        err_p_q <= 1'b0;
        err_l_q <= 1'b0;
      end
      if (seq_err) begin
        err_e_q <= 1'b1;
        err_p_q <= 1'b1;
      end
      if (lock_hit) begin
        err_l_q <= 1'b1;
        if (op == WOP_PROG) err_p_q <= 1'b1;
        else                err_e_q <= 1'b1;
      end
    end
  end

  assign rmode    = rmode_q;
  assign err_bits = {err_e_q, err_p_q, err_l_q};

  a_r1_prog_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG_DATA && fire) |-> start);

  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BUF_DATA) |-> (idx_q <= cnt_q));

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BUF_DATA) |-> (16'(cnt_q) <= (x16 ? WMAX : BMAX)));

  a_r4_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BUF_CONFIRM && fire && cmd != CMD_CONFIRM) |=>
      (err_e_q && err_p_q && state_q == S_IDLE));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ARR_BYTES = 128,
  parameter int BLK_BYTES = 32,
  parameter int BUF_BYTES = 32,
  parameter int ERASE_CYC = 8,
  parameter int PROG_TAIL = 2,
  localparam int AW = $clog2(ARR_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x16_mode,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic [15:0]   rd_oe
);

  localparam int BUF_W = $clog2(BUF_BYTES);
  localparam int NB_W  = BUF_W + 1;

  logic             fire, busy, lock_hit, start, bw_en, bw_two;
  wsm_op_e          op;
  logic [AW-1:0]    st_addr, rba;
  logic [NB_W-1:0]  nbytes;
  logic [BUF_W-1:0] bw_idx, br_idx;
  logic [7:0]       br_byte, rd_lo, rd_hi, sr;
  rd_mode_e         rmode;
  logic [2:0]       err_bits;

  assign wr_ready = !busy;
  assign fire     = wr_valid && wr_ready;
  assign rba      = x16_mode ? {rd_addr[AW-2:0], 1'b0} : rd_addr;
  assign sr       = {!busy, 1'b0, err_bits[2], err_bits[1], 2'b00, err_bits[0], 1'b0};

  flash_cmd_dec #(.ARR_BYTES(ARR_BYTES), .BUF_BYTES(BUF_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .x16(x16_mode),
    .wr_addr(wr_addr), .wr_data(wr_data), .lock_hit(lock_hit),
    .start(start), .op(op), .st_addr(st_addr), .nbytes(nbytes),
    .bw_en(bw_en), .bw_two(bw_two), .bw_idx(bw_idx),
    .rmode(rmode), .err_bits(err_bits)
  );

  flash_wbuf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .we(bw_en), .two(bw_two), .widx(bw_idx), .wdata(wr_data),
    .ridx(br_idx), .rdata(br_byte)
  );

  flash_wsm #(
    .ARR_BYTES(ARR_BYTES), .BLK_BYTES(BLK_BYTES), .BUF_BYTES(BUF_BYTES),
    .ERASE_CYC(ERASE_CYC), .PROG_TAIL(PROG_TAIL)
  ) u_wsm (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(st_addr),
    .nbytes(nbytes), .busy(busy), .lock_hit(lock_hit),
    .buf_idx(br_idx), .buf_byte(br_byte),
    .rd_addr(rba), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  always_comb begin
    if (busy) begin
      rd_data = 16'h0000;
      rd_oe   = 16'h0080;
    end else begin
      case (rmode)
        RM_STATUS: begin
          rd_data = {8'h00, sr};
          rd_oe   = 16'h00FF;
        end
        RM_XSTATUS: begin
          rd_data = {8'h00, XSTAT_FREE};
          rd_oe   = 16'h00FF;
        end
        default: begin
          rd_data = x16_mode ? {rd_hi, rd_lo} : {8'h00, rd_lo};
          rd_oe   = x16_mode ? 16'hFFFF : 16'h00FF;
        end
      endcase
    end
  end

endmodule

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x16_mode = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data, rd_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .x16_mode(x16_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [6:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [15:0] oe;
    logic [3:0]  req;
  } vec_t;

  localparam logic [1:0] K_WR = 2'd0;
  localparam logic [1:0] K_RD = 2'd1;
  localparam logic [1:0] K_WT = 2'd2;
  localparam int NV = 40;

  // Word mode throughout the table.
  localparam vec_t VEC [NV] = '{
    '{K_RD, 7'd0,  16'h0000, 16'hFFFF, 16'hFFFF, 4'd11}, // R11 erased after reset
    '{K_WR, 7'd0,  16'h0040, 16'h0, 16'h0, 4'd1},
    '{K_WR, 7'd5,  16'h1234, 16'h0, 16'h0, 4'd1},
    '{K_WT, 7'd0,  16'h0, 16'h0, 16'h0, 4'd7},
    '{K_RD, 7'd5,  16'h0, 16'h0080, 16'h00FF, 4'd10},    // R10 status mode
    '{K_WR, 7'd0,  16'h00FF, 16'h0, 16'h0, 4'd10},
    '{K_RD, 7'd5,  16'h0, 16'h1234, 16'hFFFF, 4'd1},     // R1 via 40h
    '{K_WR, 7'd0,  16'h0010, 16'h0, 16'h0, 4'd1},
    '{K_WR, 7'd6,  16'hA5F0, 16'h0, 16'h0, 4'd1},
    '{K_WT, 7'd0,  16'h0, 16'h0, 16'h0, 4'd7},
    '{K_WR, 7'd0,  16'h00FF, 16'h0, 16'h0, 4'd10},
    '{K_RD, 7'd6,  16'h0, 16'hA5F0, 16'hFFFF, 4'd1},     // R1 via 10h
    '{K_WR, 7'd0,  16'h0040, 16'h0, 16'h0, 4'd1},
    '{K_WR, 7'd5,  16'hFF00, 16'h0, 16'h0, 4'd1},
    '{K_WT, 7'd0,  16'h0, 16'h0, 16'h0, 4'd7},
    '{K_WR, 7'd0,  16'h00FF, 16'h0, 16'h0, 4'd10},
    '{K_RD, 7'd5,  16'h0, 16'h1200, 16'hFFFF, 4'd1},     // R1 AND of old and new
    '{K_WR, 7'd16, 16'h00E8, 16'h0, 16'h0, 4'd2},
    '{K_RD, 7'd16, 16'h0, 16'h0080, 16'h00FF, 4'd10},    // R10 extended status
    '{K_WR, 7'd16, 16'h0002, 16'h0, 16'h0, 4'd2},
    '{K_WR, 7'd16, 16'h1111, 16'h0, 16'h0, 4'd2},
    '{K_WR, 7'd17, 16'h2222, 16'h0, 16'h0, 4'd2},
    '{K_WR, 7'd18, 16'h3333, 16'h0, 16'h0, 4'd2},
    '{K_WR, 7'd16, 16'h00D0, 16'h0, 16'h0, 4'd2},
    '{K_WT, 7'd0,  16'h0, 16'h0, 16'h0, 4'd7},
    '{K_WR, 7'd0,  16'h00FF, 16'h0, 16'h0, 4'd10},
    '{K_RD, 7'd16, 16'h0, 16'h1111, 16'hFFFF, 4'd2},     // R2
    '{K_RD, 7'd17, 16'h0, 16'h2222, 16'hFFFF, 4'd2},
    '{K_RD, 7'd18, 16'h0, 16'h3333, 16'hFFFF, 4'd2},
    '{K_RD, 7'd19, 16'h0, 16'hFFFF, 16'hFFFF, 4'd2},     // R2 stops after N+1
    '{K_WR, 7'd16, 16'h0020, 16'h0, 16'h0, 4'd5},
    '{K_WR, 7'd16, 16'h00D0, 16'h0, 16'h0, 4'd5},
    '{K_WT, 7'd0,  16'h0, 16'h0, 16'h0, 4'd7},
    '{K_WR, 7'd0,  16'h00FF, 16'h0, 16'h0, 4'd10},
    '{K_RD, 7'd17, 16'h0, 16'hFFFF, 16'hFFFF, 4'd5},     // R5 block erased
    '{K_RD, 7'd5,  16'h0, 16'h1200, 16'hFFFF, 4'd5},     // R5 other block kept
    '{K_WR, 7'd0,  16'hAB70, 16'h0, 16'h0, 4'd6},
    '{K_RD, 7'd0,  16'h0, 16'h0080, 16'h00FF, 4'd6},     // R6 upper byte ignored
    '{K_WR, 7'd0,  16'h12FF, 16'h0, 16'h0, 4'd6},
    '{K_RD, 7'd5,  16'h0, 16'h1200, 16'hFFFF, 4'd6}      // R6
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a,
                        input logic [15:0] ed, input logic [15:0] eo);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, rd_data, ed);
    chk(req, rd_oe, eo);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R7: actual=hung expected=idle (watchdog)");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 16'(wr_ready), 16'h0001);
    wr(0, 16'h0070);
    rd_chk("R11", 0, 16'h0080, 16'h00FF);
    wr(0, 16'h00FF);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR: wr(VEC[i].addr, VEC[i].data);
        K_RD: rd_chk($sformatf("R%0d", VEC[i].req), VEC[i].addr, VEC[i].exp, VEC[i].oe);
        default: wait_idle();
      endcase
    end

    // R7 busy window right after a program starts
    wr(0, 16'h0040);
    wr(7, 16'h0F0F);
    chk("R7", 16'(wr_ready), 16'h0000);
    chk("R7", rd_oe, 16'h0080);
    chk("R7", rd_data, 16'h0000);
    wait_idle();
    chk("R7", 16'(wr_ready), 16'h0001);

    // R4 wrong byte in the buffered-write confirm slot
    wr(32, 16'h00E8);
    wr(32, 16'h0001);
    wr(32, 16'hAAAA);
    wr(33, 16'hBBBB);
    wr(32, 16'h0040);
    wr(0, 16'h0070);
    rd_chk("R4", 0, 16'h00B0, 16'h00FF);
    wr(0, 16'h00FF);
    rd_chk("R4", 32, 16'hFFFF, 16'hFFFF);
    wr(0, 16'h0050);
    wr(0, 16'h0070);
    rd_chk("R10", 0, 16'h0080, 16'h00FF);

    // R5 wrong byte in the erase confirm slot
    wr(5, 16'h0020);
    wr(5, 16'h00FF);
    rd_chk("R5", 0, 16'h00B0, 16'h00FF);
    wr(0, 16'h0050);
    wr(0, 16'h00FF);
    rd_chk("R5", 5, 16'h1200, 16'hFFFF);

    // R3 word count one past the limit, then the limit itself
    wr(48, 16'h00E8);
    wr(48, 16'h0010);
    rd_chk("R3", 0, 16'h00B0, 16'h00FF);
    wr(0, 16'h0050);
    wr(48, 16'h00E8);
    wr(48, 16'h000F);
    for (int i = 0; i < 16; i++) wr(7'(48 + i), (i == 15) ? 16'h00C3 : 16'hFFFF);
    wr(48, 16'h00D0);
    wait_idle();
    wr(0, 16'h00FF);
    rd_chk("R3", 63, 16'h00C3, 16'hFFFF);
    rd_chk("R3", 62, 16'hFFFF, 16'hFFFF);

    // R8 / R9 locking
    wr(0, 16'h0060);
    wr(48, 16'h0001);
    wait_idle();
    wr(0, 16'h0040);
    wr(48, 16'h0000);
    rd_chk("R9", 0, 16'h0092, 16'h00FF);
    wr(0, 16'h00FF);
    rd_chk("R9", 48, 16'hFFFF, 16'hFFFF);
    wr(0, 16'h0050);
    wr(48, 16'h0020);
    wr(48, 16'h00D0);
    rd_chk("R9", 0, 16'h00A2, 16'h00FF);
    wr(0, 16'h0060);
    wr(0, 16'h00D0);
    wait_idle();
    wr(0, 16'h0050);
    wr(48, 16'h0040);
    wr(48, 16'h5555);
    wait_idle();
    rd_chk("R8", 0, 16'h0080, 16'h00FF);
    wr(0, 16'h00FF);
    rd_chk("R8", 48, 16'h5555, 16'hFFFF);

    // Byte mode
    @(negedge clk);
    x16_mode = 1'b0;
    wr(0, 16'h0040);
    wr(1, 16'h003C);
    wait_idle();
    wr(0, 16'h00FF);
    rd_chk("R1", 1, 16'h003C, 16'h00FF);
    wr(0, 16'h00E8);
    wr(0, 16'h001F);
    for (int i = 0; i < 32; i++) wr(7'(64 + i), 16'(i));
    wr(64, 16'h00D0);
    wait_idle();
    wr(0, 16'h00FF);
    rd_chk("R3", 64, 16'h0000, 16'h00FF);
    rd_chk("R3", 95, 16'h001F, 16'h00FF);
    wr(0, 16'h00E8);
    wr(0, 16'h0020);
    rd_chk("R3", 0, 16'h00B0, 16'h00FF);
    wr(0, 16'h0050);

    @(negedge clk);
    x16_mode = 1'b1;
    wr(0, 16'h00FF);
    rd_chk("R10", 0, 16'h3CFF, 16'hFFFF);
    rd_chk("R2", 32, 16'h0100, 16'hFFFF);

    finish_run();
  end

endmodule